// File: doc/BRIEF.md
# Two-way cache lookup with way prediction

This block is the lookup stage of a small two-way set-associative cache. Every set carries a bit that records which way is expected to hold the next block asked for from that set. The read-data multiplexer is steered by that bit as soon as the set index is known, so the expected way's contents sit on the response bus before the tag comparison resolves. When the guess is right the requester gets its data on the fastest path. When the block sits in the other way, the response comes one cycle later with a slow-hit flag, and the per-set guess is retrained to the way that actually hit.

Tags, valid bits and data are held in registers. The block size is one data word. The number of sets is the cache size divided by the product of block size and associativity. The address splits into a byte offset (low bits), a set index (next bits) and a tag (remaining high bits). A miss is reported at once, and the block then waits on a fill port for the missing word. The fill goes into the least recently used way of the set, tracked with one bit per set. Requests use a valid/ready handshake. `req_ready` is high only while the block is idle, so a requester must hold `req_valid` and `req_addr` until it is accepted. Fills use the same handshake on `fill_valid`/`fill_ready`. Responses carry no back-pressure: `rsp_valid` is held for exactly one cycle and must be taken when it appears.

Top module: `wp_cache_lookup`

## Requirements
- R1: After reset every line is invalid, so the first request to any address misses. Every prediction bit selects way 0, and way 0 is the first victim of every set.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the response is finished, including any fill.
- R3: When the predicted way hits, the cycle right after acceptance shows `rsp_valid`=1, `rsp_hit`=1, `rsp_slow_hit`=0 and `rsp_miss`=0, with the stored block on `rsp_data`.
- R4: When only the non-predicted way hits, the cycle after acceptance has `rsp_valid`=0. The following cycle shows `rsp_valid`=1, `rsp_hit`=1, `rsp_slow_hit`=1 and `rsp_miss`=0, with the correct block on `rsp_data`.
- R5: A slow hit rewrites the set's prediction to the way that hit, so the next request for the same block is a fast hit (R3).
- R6: When neither way hits, the cycle after acceptance shows `rsp_valid`=1, `rsp_miss`=1, `rsp_hit`=0 and `rsp_slow_hit`=0. From the next cycle `fill_ready` stays high until a fill is accepted, and `req_ready` returns high in the cycle after the fill.
- R7: A fill writes `fill_data` into the set's least recently used way. That way becomes the predicted way, so the next request for the filled block is a fast hit.
- R8: Every hit and every fill makes the touched way the most recently used of its set. The next miss in that set therefore evicts the other way, and the block in the touched way still hits.
- R9: `fill_valid` while `fill_ready` is low has no effect: stored blocks, outcomes and handshake signals are unchanged.
- R10: At most one of fast hit, slow hit and miss is signalled in any cycle. A way whose valid bit is clear never produces a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle, request will be accepted |
| req_addr | input | ADDR_W | Byte address of the lookup |
| rsp_valid | output | 1 | Response outcome present this cycle |
| rsp_hit | output | 1 | Block found (fast or slow) |
| rsp_slow_hit | output | 1 | Block found in the non-predicted way |
| rsp_miss | output | 1 | Block absent, fill expected |
| rsp_data | output | DATA_W | Word from the predicted way (valid with rsp_hit) |
| fill_ready | output | 1 | Waiting for the missing block |
| fill_valid | input | 1 | Fill word present |
| fill_data | input | DATA_W | Word to install for the missed address |

## Verification
A prediction bit that is wrong inside the block shows up on the next request to that set. Either a hit that should be fast comes back a cycle late with the slow flag, or, because the mux is steered by that bit, data from the other way appears on a fast hit. A corrupted LRU bit stays hidden until the set's next miss. It then evicts the wrong block, and the error surfaces only at the next request for the block that should have survived, which is often several accesses later. The sweep therefore replays mixed tag sequences in every set, so that victim choice is checked again and again through later hit and miss outcomes.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_SLOW = 2'd2,
    ST_FILL = 2'd3
  } lk_state_e;
endpackage

// File: rtl/wp_way.sv
// One way of the cache: valid bits, tags and data words, with tag compare.
module wp_way #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  tag,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   vld;
  logic [TAG_W-1:0]  tags [SETS];
  logic [DATA_W-1:0] words[SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (wr_en) vld[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tags[idx]  <= tag;
      words[idx] <= wr_data;
    end
  end

  assign hit     = vld[idx] && (tags[idx] == tag);
  assign rd_data = words[idx];

  // R7: a freshly installed line hits for the address that filled it
  a_r7_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> hit);
endmodule

// File: rtl/wp_set_state.sv
// Per-set prediction bit and LRU bit.
module wp_set_state #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             touch_en,
  input  logic             touch_way,
  output logic             pred_way,
  output logic             lru_way
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] pred_q;
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_q <= '0;
      lru_q  <= '0;
    end else if (touch_en) begin
      pred_q[idx] <= touch_way;
      lru_q[idx]  <= ~touch_way;
    end
  end

  assign pred_way = pred_q[idx];
  assign lru_way  = lru_q[idx];

  // R5 / R8: a touched way is predicted next and is no longer the victim
  a_r8_touch_mru: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (pred_way == $past(touch_way)) && (lru_way != $past(touch_way)));
endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup
  import wp_cache_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int CACHE_BYTES = 64,
  parameter int BLOCK_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_slow_hit,
  output logic              rsp_miss,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fill_ready,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int WAYS  = 2;
  localparam int SETS  = CACHE_BYTES / (BLOCK_BYTES * WAYS);
  localparam int IDX_W = $clog2(SETS);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  lk_state_e         st;
  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  set_tag;
  logic [WAYS-1:0]   way_hit;
  logic [DATA_W-1:0] way_data [WAYS];
  logic              pred_way, lru_way;
  logic              pred_hit, alt_hit, any_hit;
  logic              req_fire, fill_fire, touch_en, touch_way;

  assign set_idx = lk_addr[OFF_W +: IDX_W];
  assign set_tag = lk_addr[ADDR_W-1 -: TAG_W];

  assign req_ready  = (st == ST_IDLE);
  assign fill_ready = (st == ST_FILL);
  assign req_fire   = req_valid && req_ready;
  assign fill_fire  = fill_valid && fill_ready;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wp_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (set_idx),
      .tag     (set_tag),
      .wr_en   (fill_fire && (lru_way == w[0])),
      .wr_data (fill_data),
      .hit     (way_hit[w]),
      .rd_data (way_data[w])
    );
  end

  wp_set_state #(.IDX_W(IDX_W)) u_set_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (set_idx),
    .touch_en  (touch_en),
    .touch_way (touch_way),
    .pred_way  (pred_way),
    .lru_way   (lru_way)
  );

  assign pred_hit = way_hit[pred_way];
  assign alt_hit  = way_hit[~pred_way];
  assign any_hit  = |way_hit;

  assign touch_en  = ((st == ST_LOOK) && any_hit) || fill_fire;
  assign touch_way = fill_fire ? lru_way : way_hit[1];

  // Data mux is steered by the prediction bit, independent of the compare.
  assign rsp_data     = way_data[pred_way];
  assign rsp_hit      = ((st == ST_LOOK) && pred_hit) || (st == ST_SLOW);
  assign rsp_slow_hit = (st == ST_SLOW);
  assign rsp_miss     = (st == ST_LOOK) && !any_hit;
  assign rsp_valid    = rsp_hit || rsp_miss;

  always_ff @(posedge clk) begin
    if (req_fire) lk_addr <= req_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE: if (req_fire) st <= ST_LOOK;
        ST_LOOK: st <= pred_hit ? ST_IDLE : (alt_hit ? ST_SLOW : ST_FILL);
        ST_SLOW: st <= ST_IDLE;
        ST_FILL: if (fill_fire) st <= ST_IDLE;
      endcase
    end
  end

  // R10: never both ways hit, and only one outcome per cycle
  a_r10_single_way: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOOK) |-> !(way_hit[0] && way_hit[1]));
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit && !rsp_slow_hit, rsp_slow_hit, rsp_miss}) == 1));
  // R4: a hit in the other way is answered slow in the next cycle
  a_r4_slow_next: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_LOOK) && alt_hit && !pred_hit) |=> (rsp_valid && rsp_slow_hit));
  // R5: the slow response already comes through the retrained prediction
  a_r5_retrained: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_slow_hit |-> way_hit[pred_way]);
  // R6: a miss opens the fill window
  a_r6_miss_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |=> (fill_ready && !req_ready));
  // R2: after a fill the block is idle again
  a_r2_fill_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> req_ready);
endmodule

// File: tb/test_wp_cache_lookup.sv
module test_wp_cache_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SETS   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic rsp_valid, rsp_hit, rsp_slow_hit, rsp_miss;
  logic [DATA_W-1:0] rsp_data;
  logic fill_ready, fill_valid = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench-side model of what the requirements promise
  int  m_tag  [SETS][2];
  bit  m_vld  [SETS][2];
  bit  m_pred [SETS];
  bit  m_lru  [SETS];
  bit  m_slow_last [SETS];
  bit  m_fill_last [SETS];
  int  m_last_tag  [SETS];

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_cache_lookup i_wp_cache_lookup (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_slow_hit(rsp_slow_hit),
    .rsp_miss(rsp_miss), .rsp_data(rsp_data),
    .fill_ready(fill_ready), .fill_valid(fill_valid), .fill_data(fill_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] blk_word(input logic [ADDR_W-1:0] a);
    logic [15:0] b = a & 16'hFFFC;
    return {~b, b};
  endfunction

  task automatic access(input int idx, input int tag, input int off);
    logic [ADDR_W-1:0] a = ADDR_W'((tag << 5) | (idx << 2) | off);
    int hw = -1;
    string lbl;
    for (int w = 0; w < 2; w++)
      if (m_vld[idx][w] && m_tag[idx][w] == tag) hw = w;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy", {63'd0, req_ready}, 64'd0);
    if (hw >= 0 && hw == int'(m_pred[idx])) begin
      lbl = (m_slow_last[idx] && m_last_tag[idx] == tag) ? "R5 fast after slow" :
            (m_fill_last[idx] && m_last_tag[idx] == tag) ? "R7 fast after fill" :
            (m_vld[idx][0] && m_vld[idx][1]) ? "R8 fast hit" : "R3 fast hit";
      chk(lbl, {60'd0, rsp_valid, rsp_hit, rsp_slow_hit, rsp_miss}, 64'b1100);
      chk("R3 data", {32'd0, rsp_data}, {32'd0, blk_word(a)});
      m_lru[idx] = !hw[0];
      m_slow_last[idx] = 0; m_fill_last[idx] = 0;
    end else if (hw >= 0) begin
      chk("R4 no early rsp", {63'd0, rsp_valid}, 64'd0);
      @(negedge clk);
      chk("R4 slow hit", {60'd0, rsp_valid, rsp_hit, rsp_slow_hit, rsp_miss}, 64'b1110);
      chk("R4 data", {32'd0, rsp_data}, {32'd0, blk_word(a)});
      m_pred[idx] = hw[0]; m_lru[idx] = !hw[0];
      m_slow_last[idx] = 1; m_fill_last[idx] = 0;
    end else begin
      int v = int'(m_lru[idx]);
      lbl = (!m_vld[idx][0] && !m_vld[idx][1]) ? "R1 cold miss" :
            (m_vld[idx][0] && m_vld[idx][1]) ? "R8 miss" : "R6 miss";
      chk(lbl, {60'd0, rsp_valid, rsp_hit, rsp_slow_hit, rsp_miss}, 64'b1001);
      fill_valid = 1'b1; fill_data = blk_word(a);
      @(negedge clk);
      chk("R6 fill window", {62'd0, fill_ready, req_ready}, 64'b10);
      @(negedge clk);
      fill_valid = 1'b0;
      chk("R6 ready after fill", {62'd0, req_ready, fill_ready}, 64'b10);
      m_vld[idx][v] = 1; m_tag[idx][v] = tag;
      m_pred[idx] = v[0]; m_lru[idx] = !v[0];
      m_fill_last[idx] = 1; m_slow_last[idx] = 0;
    end
    m_last_tag[idx] = tag;
    @(negedge clk);
    chk("R2 idle", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic stray_fill();
    @(negedge clk);
    fill_valid = 1'b1; fill_data = 32'hDEADBEEF;
    @(negedge clk);
    chk("R9 stray fill ignored", {61'd0, req_ready, fill_ready, rsp_valid}, 64'b100);
    fill_valid = 1'b0;
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_pred[s] = 0; m_lru[s] = 0; m_slow_last[s] = 0; m_fill_last[s] = 0;
      m_last_tag[s] = -1;
      for (int w = 0; w < 2; w++) begin m_vld[s][w] = 0; m_tag[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset handshake", {61'd0, req_ready, fill_ready, rsp_valid}, 64'b100);
    // R1: every set misses first, fill lands in way 0
    for (int s = 0; s < SETS; s++) access(s, 1, 0);
    // directed: A,B,A to show slow hit then retrain (R4, R5), C evicts LRU (R8)
    access(0, 2, 1);
    access(0, 1, 2);
    access(0, 1, 3);
    access(0, 3, 0);
    access(0, 1, 0);
    access(0, 2, 0);
    // sweep over all sets with mixed tag sequences
    for (int k = 0; k < 640; k++) begin
      int idx = k % SETS;
      int r   = k / SETS;
      int tag = (r + (r >> 1) * idx + (r >> 3)) % 3;
      if (k % 5 == 2) stray_fill();
      access(idx, tag, k % 4);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2: watchdog expired, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule